// File: doc/BRIEF.md
# Dual-Mode Pixel Output Sequencer

This block sits between video memory and the colour digital-to-analogue stage of a simple raster display. Every pixel slot (two master-clock cycles) it takes one 16-bit video word holding two 8-bit pixels. It latches both pixels and drives a 7-bit colour code for each master-clock cycle of the slot that follows. In high-resolution mode the two pixels appear one after the other, one master cycle each. In layer mode the high byte is a foreground pixel and the low byte a background pixel. The foreground's top bit marks it transparent, and a single choice holds for the whole slot.

The block also divides the master clock. It produces a half-rate and a quarter-rate square wave and a quarter-rate processor clock that is low for only one master cycle in four. A processor-access flag, sampled at each slot boundary, stops the pixel registers from loading and freezes the colour output, so the screen keeps showing its last colour while the processor owns the memory. With neither mode register enabled, the output is forced to colour code zero.

Top module: `pixseq_top`

## Requirements
- R1: While rst_n is low, color is 0, clk_div2 and clk_div4 are 0 and cpu_clk is 1.
- R2: A 2-bit phase counter advances every master cycle. clk_div2 is its bit 0 and toggles every cycle; clk_div4 is its bit 1 and toggles every second cycle.
- R3: cpu_clk is low in exactly one master cycle of every four, the cycle in which clk_div2 and clk_div4 are both 1.
- R4: A slot boundary is a rising edge at which clk_div2 is 1. In high-resolution mode, the cycle after the boundary shows bits 6:0 of pix_word[7:0] and the next cycle shows bits 6:0 of pix_word[15:8].
- R5: In layer mode with pix_word[15] = 0, both cycles of the slot show pix_word[14:8].
- R6: In layer mode with pix_word[15] = 1 (transparent foreground), both cycles of the slot show pix_word[6:0].
- R7: Bit 7 of either pixel never reaches color; only bits 6:0 of the chosen pixel are driven.
- R8: When hires_en and layer_en are both 1 at a slot boundary, high-resolution mode is used.
- R9: When hires_en and layer_en are both 0 at a slot boundary, color is 0 in both cycles of the slot.
- R10: When cpu_access is 1 at a slot boundary, the word is not latched and color holds its previous value for both cycles of that slot. The next slot without access shows its own word normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_word | input | 16 | Two pixels: low byte first/background, high byte second/foreground |
| hires_en | input | 1 | High-resolution mode register output |
| layer_en | input | 1 | Layer mode register output |
| cpu_access | input | 1 | Processor owns video memory; freezes latching and output |
| color | output | 7 | Colour code to the converters |
| clk_div2 | output | 1 | Master clock divided by two |
| clk_div4 | output | 1 | Master clock divided by four |
| cpu_clk | output | 1 | Quarter-rate processor clock, low one cycle in four |

## Verification
The hardest behaviour to reach from the ports is the processor-access freeze. The flag only matters at a slot boundary, and the held colour must survive the second half of the slot, where a normal slot would move on to the second pixel. The stimulus uses the clk_div2 output to find the boundary phase. It first shows a slot whose two pixels differ, then raises the access flag for two slots carrying a different word. It checks that the last shown colour persists in all four cycles and that the next normal slot shows the fresh word, not the word offered during the access.

// File: rtl/pixseq_pkg.sv
package pixseq_pkg;

  typedef enum logic [1:0] {
    SHOW_BLANK = 2'd0,
    SHOW_HIRES = 2'd1,
    SHOW_LAYER = 2'd2
  } show_mode_t;

  // High-resolution wins when both registers are set.
  function automatic show_mode_t decide_mode(input logic hi, input logic lay);
    if (hi)       return SHOW_HIRES;
    else if (lay) return SHOW_LAYER;
    else          return SHOW_BLANK;
  endfunction

endpackage

// File: rtl/pixseq_clkdiv.sv
module pixseq_clkdiv (
  input  logic clk,
  input  logic rst_n,
  output logic clk_div2,
  output logic clk_div4,
  output logic cpu_clk,
  output logic slot_edge
);
  localparam int PH_W = 2;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign clk_div2  = phase[0];
  assign clk_div4  = phase[1];
  assign cpu_clk   = ~&phase;
  assign slot_edge = phase[0];

  AST_CPU_LOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk |=> cpu_clk); // R3
  AST_DIV4_ON_DIV2_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_div4) |-> $fell(clk_div2)); // R2
  AST_DIV2_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div2 |=> !clk_div2); // R2

endmodule

// File: rtl/pixseq_latch.sv
module pixseq_latch
  import pixseq_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_edge,
  input  logic             hold,
  input  logic [2*PIX_W-1:0] word,
  input  show_mode_t       mode_in,
  output logic [PIX_W-1:0] pix_lo,
  output logic [PIX_W-1:0] pix_hi,
  output show_mode_t       mode_q,
  output logic             slot_live
);
  logic do_load;
  assign do_load = slot_edge && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_lo    <= '0;
      pix_hi    <= '0;
      mode_q    <= SHOW_BLANK;
      slot_live <= 1'b0;
    end else if (slot_edge) begin
      slot_live <= !hold;
      if (do_load) begin
        pix_lo <= word[PIX_W-1:0];
        pix_hi <= word[2*PIX_W-1:PIX_W];
        mode_q <= mode_in;
      end
    end
  end

  AST_HOLD_KEEPS_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && hold) |=> ($stable(pix_lo) && $stable(pix_hi))); // R10
  AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (pix_hi == $past(word[2*PIX_W-1:PIX_W]))); // R4

endmodule

// File: rtl/pixseq_select.sv
module pixseq_select
  import pixseq_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COLOR_W = 7
) (
  input  show_mode_t         mode_now,
  input  logic [2*PIX_W-1:0] word,
  input  show_mode_t         mode_q,
  input  logic [PIX_W-1:0]   pix_lo,
  input  logic [PIX_W-1:0]   pix_hi,
  output logic [COLOR_W-1:0] first_col,
  output logic [COLOR_W-1:0] second_col
);
  localparam int SEL_BIT = PIX_W - 1;

  function automatic logic [PIX_W-1:0] layer_pick(input logic [PIX_W-1:0] bg,
                                                  input logic [PIX_W-1:0] fg);
    return fg[SEL_BIT] ? bg : fg;
  endfunction

  function automatic logic [COLOR_W-1:0] shade(input show_mode_t m,
                                               input logic [PIX_W-1:0] bg,
                                               input logic [PIX_W-1:0] fg,
                                               input logic second);
    logic [PIX_W-1:0] p;
    case (m)
      SHOW_HIRES: p = second ? fg : bg;
      SHOW_LAYER: p = layer_pick(bg, fg);
      default:    p = '0;
    endcase
    return p[COLOR_W-1:0];
  endfunction

  assign first_col  = shade(mode_now, word[PIX_W-1:0], word[2*PIX_W-1:PIX_W], 1'b0);
  assign second_col = shade(mode_q, pix_lo, pix_hi, 1'b1);

endmodule

// File: rtl/pixseq_top.sv
module pixseq_top
  import pixseq_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COLOR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*PIX_W-1:0]   pix_word,
  input  logic                 hires_en,
  input  logic                 layer_en,
  input  logic                 cpu_access,
  output logic [COLOR_W-1:0]   color,
  output logic                 clk_div2,
  output logic                 clk_div4,
  output logic                 cpu_clk
);
  logic             slot_edge;
  show_mode_t       mode_now;
  show_mode_t       mode_q;
  logic [PIX_W-1:0] pix_lo;
  logic [PIX_W-1:0] pix_hi;
  logic             slot_live;
  logic [COLOR_W-1:0] first_col;
  logic [COLOR_W-1:0] second_col;
  logic             show_first;
  logic             show_second;

  assign mode_now = decide_mode(hires_en, layer_en);

  pixseq_clkdiv u_clkdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_div2 (clk_div2),
    .clk_div4 (clk_div4),
    .cpu_clk  (cpu_clk),
    .slot_edge(slot_edge)
  );

  pixseq_latch #(.PIX_W(PIX_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_edge(slot_edge),
    .hold     (cpu_access),
    .word     (pix_word),
    .mode_in  (mode_now),
    .pix_lo   (pix_lo),
    .pix_hi   (pix_hi),
    .mode_q   (mode_q),
    .slot_live(slot_live)
  );

  pixseq_select #(.PIX_W(PIX_W), .COLOR_W(COLOR_W)) u_select (
    .mode_now  (mode_now),
    .word      (pix_word),
    .mode_q    (mode_q),
    .pix_lo    (pix_lo),
    .pix_hi    (pix_hi),
    .first_col (first_col),
    .second_col(second_col)
  );

  assign show_first  = slot_edge && !cpu_access;
  assign show_second = !slot_edge && slot_live;

  always_ff @(posedge clk) begin
    if (!rst_n)           color <= '0;
    else if (show_first)  color <= first_col;
    else if (show_second) color <= second_col;
  end

  AST_ACCESS_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && cpu_access) |=> $stable(color)); // R10
  AST_ACCESS_FREEZES_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && cpu_access) |=> ##1 $stable(color)); // R10
  AST_BLANK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && !cpu_access && !hires_en && !layer_en) |=> (color == '0)); // R9
  AST_HIRES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && !cpu_access && hires_en) |=> (color == $past(pix_word[COLOR_W-1:0]))); // R8

endmodule

// File: tb/test_pixseq_top.sv
module test_pixseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pix_word = '0;
  logic        hires_en = 1'b0;
  logic        layer_en = 1'b0;
  logic        cpu_access = 1'b0;
  logic [6:0]  color;
  logic        clk_div2, clk_div4, cpu_clk;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pixseq_top i_pixseq_top (
    .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .hires_en(hires_en),
    .layer_en(layer_en), .cpu_access(cpu_access), .color(color),
    .clk_div2(clk_div2), .clk_div4(clk_div4), .cpu_clk(cpu_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    while (clk_div2 !== 1'b1) @(negedge clk);
  endtask

  // Offers one word at a slot boundary and checks both cycles of the slot.
  task automatic run_slot(input logic [15:0] w, input logic h, input logic l,
                          input logic acc, input logic [6:0] e1,
                          input logic [6:0] e2, input string req);
    align();
    pix_word = w; hires_en = h; layer_en = l; cpu_access = acc;
    @(negedge clk);
    check({req, " first"}, color, e1);
    @(negedge clk);
    check({req, " second"}, color, e2);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 color", color, 0);
    check("R1 div2", clk_div2, 0);
    check("R1 div4", clk_div4, 0);
    check("R1 cpu_clk", cpu_clk, 1);
  endtask

  task automatic test_dividers();
    logic p2, p4;
    int lows = 0;
    @(negedge clk);
    p2 = clk_div2; p4 = clk_div4;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 div2 toggles", clk_div2, !p2);
      if (p2 && !clk_div2) check("R2 div4 toggles", clk_div4, !p4);
      else                 check("R2 div4 steady", clk_div4, p4);
      check("R3 cpu_clk low only when both high", cpu_clk, !(clk_div2 && clk_div4));
      if (!cpu_clk) lows++;
      p2 = clk_div2; p4 = clk_div4;
    end
    check("R3 low count per 8 cycles", lows, 2);
  endtask

  task automatic test_hires();
    run_slot(16'h8A35, 1, 0, 0, 7'h35, 7'h0A, "R4 R7 hires");
    run_slot(16'h7F81, 1, 0, 0, 7'h01, 7'h7F, "R4 R7 hires top bits");
  endtask

  task automatic test_layer();
    run_slot(16'h1255, 0, 1, 0, 7'h12, 7'h12, "R5 layer foreground");
    run_slot(16'h93C4, 0, 1, 0, 7'h44, 7'h44, "R6 layer transparent");
  endtask

  task automatic test_priority();
    run_slot(16'h2233, 1, 1, 0, 7'h33, 7'h22, "R8 both enabled");
  endtask

  task automatic test_blank();
    run_slot(16'h7777, 0, 0, 0, 7'h00, 7'h00, "R9 blank");
  endtask

  task automatic test_access();
    run_slot(16'h6655, 1, 0, 0, 7'h55, 7'h66, "R10 before access");
    run_slot(16'h1111, 1, 0, 1, 7'h66, 7'h66, "R10 access hold");
    run_slot(16'h2929, 0, 1, 1, 7'h66, 7'h66, "R10 access hold again");
    run_slot(16'h0C0B, 1, 0, 0, 7'h0B, 7'h0C, "R10 after access");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_dividers();
        test_hires();
        test_layer();
        test_priority();
        test_blank();
        test_access();
      end
      begin
        repeat (5000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule